// File: doc/BRIEF.md
# Test-Point Scan Sequencer

This block walks a list of test-point numbers stored in a small on-chip RAM and measures each point in turn. For every entry it first asks the converter controller to set the comparator reference, and waits for that request to be acknowledged. It then reads the point number and drives it onto the switch-select output with the switch enable raised. After a programmable settle time it samples the comparator. The verdict and the point number are packed into one word, and that word is written back over the entry it came from.

The operation code picks the procedure and so the pass polarity of the comparator: a switch self-check, a continuity test or an insulation test. The host side loads the point list through a plain RAM port while the sequencer is idle and reads the results back through the same port once the scan is over. While a scan runs, the sequencer owns the RAM and host writes are dropped.

Top module: `scan_sequencer`

## Requirements
- R1: After reset `busy`, `done`, `ref_req` and `sw_en` are all low.
- R2: `start` is ignored when `opcode` is 2'b00 and while `busy` is high. An ignored start raises no request, writes no RAM entry and does not change the procedure of a running scan.
- R3: Each point begins with `ref_req` high. `ref_req` stays high until `ref_ack` is seen, and `ref_sel` carries the running opcode meanwhile. `sw_en` is never high while `ref_req` is high. There is exactly one request per point.
- R4: Entries are visited in ascending address order from 0. For entry k, `sw_sel` carries bits 11:0 of the word that entry k held.
- R5: `sw_en` stays high for exactly `settle_dly`+1 cycles per point. The comparator is sampled on the clock edge that ends the last of those cycles, so a delay of 0 samples one cycle after the switch is driven.
- R6: The result is written over the entry that held the point. Bit 12 of the result is the verdict (1 = pass) and bits 11:0 are the point number.
- R7: Codes 2'b01 (self-check) and 2'b10 (continuity) pass when `cmp_in` is 1. Code 2'b11 (insulation) passes when `cmp_in` is 0.
- R8: A scan covers entries 0 to N-1, where N is `point_count` clamped to the RAM depth, and entries at N and above are left unchanged. N = 0 gives a `done` pulse in the cycle after start and raises no request.
- R9: `done` is a one-cycle pulse in the cycle after the last result write. `busy` is low in that cycle.
- R10: While idle, a host write stores `host_wdata` at `host_addr`, and `host_rdata` shows the addressed entry one cycle after the address. While `busy`, host writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a scan (sampled while idle) |
| opcode | input | 2 | Procedure: 01 self-check, 10 continuity, 11 insulation |
| settle_dly | input | DLY_W | Settle cycles after the switch is driven |
| point_count | input | ADDR_W+1 | Number of entries to scan |
| ref_req | output | 1 | Reference-set request to the converter controller |
| ref_sel | output | 2 | Procedure code accompanying the request |
| ref_ack | input | 1 | Reference set acknowledge |
| sw_en | output | 1 | Switch enable for the point under test |
| sw_sel | output | PT_W | Point number under test |
| cmp_in | input | 1 | Comparator result |
| busy | output | 1 | Scan in progress; sequencer owns the RAM |
| done | output | 1 | One-cycle end-of-scan pulse |
| host_we | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host RAM address |
| host_wdata | input | PT_W+1 | Host write data |
| host_rdata | output | PT_W+1 | RAM read data (one-cycle latency) |

## Verification
The two functions that can fall into one cycle are the host write port and the sequencer's result write-back, because both target the single RAM port. The bench provokes this with a zero-cycle settle delay, which makes the switch-enable cycle also the write-back cycle. It watches for that cycle and drives a host write of a distinct pattern to the same entry in that same cycle. After the scan, the entry must hold the packed result rather than the host pattern. In the same scan a second start with the insulation code is issued, and the verdict polarity must stay that of continuity.

// File: rtl/scan_pkg.sv
package scan_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_SELF  = 2'b01,
      OP_CONT  = 2'b10,
      OP_INSUL = 2'b11
   } scan_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REF,
      ST_RD,
      ST_LAT,
      ST_WAIT
   } scan_st_e;

   // verdict polarity per procedure: insulation passes on a low comparator
   function automatic logic scan_verdict(scan_op_e op, logic cmp);
      return (op == OP_INSUL) ? ~cmp : cmp;
   endfunction

endpackage

// File: rtl/scan_ram.sv
module scan_ram #(
   parameter int AW = 6,
   parameter int DW = 13
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
   end
endmodule

// File: rtl/scan_port_mux.sv
module scan_port_mux #(
   parameter int AW = 6,
   parameter int DW = 13
) (
   input  logic          seq_own,
   input  logic          host_we,
   input  logic [AW-1:0] host_addr,
   input  logic [DW-1:0] host_wdata,
   input  logic          seq_we,
   input  logic [AW-1:0] seq_addr,
   input  logic [DW-1:0] seq_wdata,
   output logic          ram_we,
   output logic [AW-1:0] ram_addr,
   output logic [DW-1:0] ram_wdata
);
   always_comb begin
      if (seq_own) begin
         ram_we    = seq_we;
         ram_addr  = seq_addr;
         ram_wdata = seq_wdata;
      end else begin
         ram_we    = host_we;
         ram_addr  = host_addr;
         ram_wdata = host_wdata;
      end
   end
endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
   import scan_pkg::*;
#(
   parameter int AW    = 6,
   parameter int PT_W  = 12,
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       opcode,
   input  logic [DLY_W-1:0] settle_dly,
   input  logic [AW:0]      point_count,
   input  logic             ref_ack,
   input  logic             cmp_in,
   input  logic [PT_W-1:0]  ram_pt,
   output logic             ref_req,
   output logic [1:0]       ref_sel,
   output logic             sw_en,
   output logic [PT_W-1:0]  sw_sel,
   output logic             busy,
   output logic             done,
   output logic             seq_we,
   output logic [AW-1:0]    seq_addr,
   output logic [PT_W:0]    seq_wdata
);
   localparam logic [AW:0] FULL = {1'b1, {AW{1'b0}}};

   scan_st_e          st;
   scan_op_e          op_q;
   logic [DLY_W-1:0]  dly_q;
   logic [DLY_W-1:0]  cnt;
   logic [AW:0]       tot_q;
   logic [AW-1:0]     idx;
   logic [PT_W-1:0]   pt_q;
   logic              last_pt;
   logic              sample_now;

   assign last_pt    = ({1'b0, idx} + 1'b1) == tot_q;
   assign sample_now = (st == ST_WAIT) && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         op_q  <= OP_NONE;
         dly_q <= '0;
         cnt   <= '0;
         tot_q <= '0;
         idx   <= '0;
         pt_q  <= '0;
         sw_en <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start && opcode != OP_NONE) begin
                  op_q  <= scan_op_e'(opcode);
                  dly_q <= settle_dly;
                  tot_q <= (point_count > FULL) ? FULL : point_count;
                  idx   <= '0;
                  if (point_count == '0) done <= 1'b1;
                  else                   st   <= ST_REF;
               end
            end
            ST_REF:  if (ref_ack) st <= ST_RD;
            ST_RD:   st <= ST_LAT;
            ST_LAT: begin
               pt_q  <= ram_pt;
               sw_en <= 1'b1;
               cnt   <= dly_q;
               st    <= ST_WAIT;
            end
            ST_WAIT: begin
               if (cnt == '0) begin
                  sw_en <= 1'b0;
                  if (last_pt) begin
                     done <= 1'b1;
                     st   <= ST_IDLE;
                  end else begin
                     idx <= idx + 1'b1;
                     st  <= ST_REF;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (st != ST_IDLE);
   assign ref_req   = (st == ST_REF);
   assign ref_sel   = op_q;
   assign sw_sel    = pt_q;
   assign seq_addr  = idx;
   assign seq_we    = sample_now;
   assign seq_wdata = {scan_verdict(op_q, cmp_in), pt_q};

   AST_REF_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req |-> !sw_en); // R3
   AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_req && !ref_ack) |=> ref_req); // R3
   AST_WRITE_WITH_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
      seq_we |-> sw_en); // R5
   AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en && $past(sw_en)) |-> $stable(sw_sel)); // R4
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !sw_en)); // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ref_req && !sw_en)); // R2
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
   parameter int ADDR_W = 6,
   parameter int PT_W   = 12,
   parameter int DLY_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        opcode,
   input  logic [DLY_W-1:0]  settle_dly,
   input  logic [ADDR_W:0]   point_count,
   output logic              ref_req,
   output logic [1:0]        ref_sel,
   input  logic              ref_ack,
   output logic              sw_en,
   output logic [PT_W-1:0]   sw_sel,
   input  logic              cmp_in,
   output logic              busy,
   output logic              done,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [PT_W:0]     host_wdata,
   output logic [PT_W:0]     host_rdata
);
   localparam int WORD_W = PT_W + 1;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("ADDR_W out of range");
   end
   if (PT_W < 1 || PT_W > 16) begin : g_bad_pt
      $error("PT_W out of range");
   end
   if (DLY_W < 1 || DLY_W > 32) begin : g_bad_dly
      $error("DLY_W out of range");
   end

   logic              seq_we;
   logic [ADDR_W-1:0] seq_addr;
   logic [WORD_W-1:0] seq_wdata;
   logic              ram_we;
   logic [ADDR_W-1:0] ram_addr;
   logic [WORD_W-1:0] ram_wdata;
   logic [WORD_W-1:0] ram_rdata;

   scan_fsm #(.AW(ADDR_W), .PT_W(PT_W), .DLY_W(DLY_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .opcode      (opcode),
      .settle_dly  (settle_dly),
      .point_count (point_count),
      .ref_ack     (ref_ack),
      .cmp_in      (cmp_in),
      .ram_pt      (ram_rdata[PT_W-1:0]),
      .ref_req     (ref_req),
      .ref_sel     (ref_sel),
      .sw_en       (sw_en),
      .sw_sel      (sw_sel),
      .busy        (busy),
      .done        (done),
      .seq_we      (seq_we),
      .seq_addr    (seq_addr),
      .seq_wdata   (seq_wdata)
   );

   scan_port_mux #(.AW(ADDR_W), .DW(WORD_W)) u_mux (
      .seq_own    (busy),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .seq_we     (seq_we),
      .seq_addr   (seq_addr),
      .seq_wdata  (seq_wdata),
      .ram_we     (ram_we),
      .ram_addr   (ram_addr),
      .ram_wdata  (ram_wdata)
   );

   scan_ram #(.AW(ADDR_W), .DW(WORD_W)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .addr  (ram_addr),
      .wdata (ram_wdata),
      .rdata (ram_rdata)
   );

   assign host_rdata = ram_rdata;

   AST_HOST_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ram_we) |-> sw_en); // R10
endmodule

// File: tb/scan_sequencer_test.sv
`timescale 1ns/1ps
module scan_sequencer_test;
   localparam int AW = 6;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [1:0] opcode = 2'b00;
   logic [7:0] settle_dly = '0;
   logic [AW:0] point_count = '0;
   logic ref_req;
   logic [1:0] ref_sel;
   logic ref_ack = 1'b0;
   logic sw_en;
   logic [11:0] sw_sel;
   logic cmp_in;
   logic busy, done;
   logic host_we = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [12:0] host_wdata = '0;
   logic [12:0] host_rdata;

   always #2.5 clk = ~clk;

   scan_sequencer uut (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .settle_dly(settle_dly), .point_count(point_count),
      .ref_req(ref_req), .ref_sel(ref_sel), .ref_ack(ref_ack),
      .sw_en(sw_en), .sw_sel(sw_sel), .cmp_in(cmp_in),
      .busy(busy), .done(done), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata)
   );

   int total = 0;
   int bad = 0;

   // stimulus vectors: {opcode, settle, count, ack latency}
   localparam logic [21:0] VEC [4] = '{
      {2'b10, 8'd0, 8'd5,  4'd0},
      {2'b11, 8'd3, 8'd7,  4'd2},
      {2'b01, 8'd1, 8'd4,  4'd1},
      {2'b10, 8'd6, 8'd64, 4'd0}
   };

   // environment model state
   int cur_dly = 0;
   int ack_lat = 0;
   int ack_cnt = 0;
   int hc = 0;
   logic [1:0] exp_op = 2'b00;
   int ref_cnt = 0, ref_bad = 0, sw_n = 0, cur_len = 0, len_bad = 0;
   int done_cnt = 0, done_bad = 0;
   logic [11:0] sw_log [DEPTH];
   logic prev_sw = 1'b0, prev_req = 1'b0, prev_done = 1'b0;

   function automatic logic fz(logic [11:0] s);
      return s[0] ^ s[5];
   endfunction

   function automatic logic [11:0] pt_of(int i, int v);
      return 12'((i * 97 + v * 611 + 3) & 12'hFFF);
   endfunction

   function automatic logic [12:0] res_of(logic [1:0] op, logic [11:0] p);
      return {(op == 2'b11) ? ~fz(p) : fz(p), p};
   endfunction

   // comparator settles only after the programmed delay has elapsed
   assign cmp_in = (sw_en && hc >= cur_dly) ? fz(sw_sel) : ~fz(sw_sel);

   always @(posedge clk) hc <= sw_en ? hc + 1 : 0;

   // reference acknowledge model
   always @(negedge clk) begin
      if (ref_ack) ref_ack = 1'b0;
      else if (ref_req) begin
         if (ack_cnt >= ack_lat) begin ref_ack = 1'b1; ack_cnt = 0; end
         else ack_cnt++;
      end
   end

   // observation monitor
   always @(negedge clk) begin
      if (ref_req && !prev_req) ref_cnt++;
      if (ref_req && (sw_en || ref_sel !== exp_op)) ref_bad++;
      if (sw_en && !prev_sw) begin
         if (sw_n < DEPTH) sw_log[sw_n] = sw_sel;
         sw_n++;
         cur_len = 0;
      end
      if (sw_en) cur_len++;
      if (!sw_en && prev_sw && cur_len != cur_dly + 1) len_bad++;
      if (done) begin
         done_cnt++;
         if (busy || prev_done) done_bad++;
      end
      prev_sw = sw_en; prev_req = ref_req; prev_done = done;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic hwrite(input int a, input logic [12:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic hread(input int a, output logic [12:0] d);
      @(negedge clk);
      host_addr = AW'(a);
      @(negedge clk);
      d = host_rdata;
   endtask

   task automatic fill(input int v);
      for (int i = 0; i < DEPTH; i++) hwrite(i, {1'b0, pt_of(i, v)});
   endtask

   task automatic run_scan(input logic [1:0] op, input int dly, input int cnt, input int lat);
      int w;
      @(negedge clk);
      ref_cnt = 0; ref_bad = 0; sw_n = 0; len_bad = 0; done_cnt = 0; done_bad = 0;
      cur_dly = dly; ack_lat = lat; ack_cnt = 0; exp_op = op;
      opcode = op; settle_dly = 8'(dly); point_count = (AW+1)'(cnt); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      w = 0;
      while (!done && w < 20000) begin @(negedge clk); w++; end
      if (w >= 20000) chk("R9 scan timeout", 1, 0);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [12:0] d;
      int n;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 ref_req", ref_req, 0);
      chk("R1 sw_en", sw_en, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table
      for (int v = 0; v < 4; v++) begin
         logic [1:0] op;
         int dly, cnt, lat;
         op = VEC[v][21:20]; dly = int'(VEC[v][19:12]);
         cnt = int'(VEC[v][11:4]); lat = int'(VEC[v][3:0]);
         fill(v);
         run_scan(op, dly, cnt, lat);
         chk("R3 one request per point", ref_cnt, cnt);
         chk("R3 request ordering and code", ref_bad, 0);
         chk("R5 settle length", len_bad, 0);
         chk("R9 single done pulse", done_cnt, 1);
         chk("R9 done with busy low", done_bad, 0);
         n = (cnt < DEPTH) ? cnt : DEPTH;
         for (int i = 0; i < n; i++) chk("R4 switch order", sw_log[i], pt_of(i, v));
         for (int i = 0; i < DEPTH; i++) begin
            hread(i, d);
            if (i < cnt) chk("R6 R7 result word", d, res_of(op, pt_of(i, v)));
            else         chk("R8 entry beyond count", d, {1'b0, pt_of(i, v)});
         end
      end

      // R2: opcode 00 ignored
      fill(7);
      @(negedge clk);
      opcode = 2'b00; point_count = 7'd3; start = 1'b1; ref_cnt = 0;
      @(negedge clk); start = 1'b0;
      repeat (5) @(negedge clk);
      chk("R2 null opcode busy", busy, 0);
      chk("R2 null opcode request", ref_cnt, 0);
      hread(0, d);
      chk("R2 null opcode ram", d, {1'b0, pt_of(0, 7)});

      // R8: zero count
      @(negedge clk);
      opcode = 2'b10; point_count = '0; start = 1'b1; ref_cnt = 0;
      @(negedge clk); start = 1'b0;
      chk("R8 zero count done", done, 1);
      chk("R8 zero count busy", busy, 0);
      @(negedge clk);
      chk("R8 zero count request", ref_cnt, 0);

      // R8: count above depth clamps
      fill(5);
      run_scan(2'b10, 0, 100, 0);
      chk("R8 clamp requests", ref_cnt, DEPTH);
      hread(DEPTH - 1, d);
      chk("R8 clamp last entry", d, res_of(2'b10, pt_of(DEPTH - 1, 5)));

      // R10 + R2: host write in the write-back cycle, restart while busy
      fill(9);
      fork
         run_scan(2'b10, 0, 3, 0);
         begin
            @(negedge clk);
            while (!sw_en) @(negedge clk);
            host_we = 1'b1; host_addr = '0; host_wdata = 13'h0F0F;
            @(negedge clk);
            host_we = 1'b0;
            opcode = 2'b11; start = 1'b1;
            @(negedge clk);
            start = 1'b0; opcode = 2'b10;
         end
      join
      chk("R2 restart while busy", ref_cnt, 3);
      for (int i = 0; i < 3; i++) begin
         hread(i, d);
         chk("R10 host write dropped / R2 polarity kept", d, res_of(2'b10, pt_of(i, 9)));
      end

      // R10: idle host write and read
      hwrite(10, 13'h1A5C);
      hread(10, d);
      chk("R10 idle host access", d, 13'h1A5C);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule